// File: doc/BRIEF.md
# Insert Slot Election Arbiter

This block sits at the end of one column of parallel hash sub-tables. Each sub-table unit has already read the slot that its own hash function picked for the current request. Each unit reports three things: whether that slot is empty, whether the stored key equals the request key, and the slot address. The arbiter then settles the request. A query, delete or modify request finds at most one matching unit, and that unit's value is forwarded as a success. An insert request may find several empty slots, so the arbiter elects exactly one unit to store it and drives that unit's write-back.

Memory read and write-back take several cycles, so an "empty" report can be stale. An insert granted one or two cycles earlier may not have reached the array yet. To cover this, every unit keeps a short shift-register history of the slot addresses recently granted to it. A unit whose address matches any valid history entry cannot take part in the election. Because of this, two inserts that arrive close together and hash to the same empty slot never land on top of each other. A request that reaches the block already marked as hit passes through untouched. An insert that finds no eligible unit leaves with hit clear, so the next column can try it. The result is registered, which gives exactly one cycle of latency.

Top module: `kv_insert_elector`

## Requirements
- R1: At most one bit of `grant` is ever set. A grant is issued only for a valid insert (op code 2'b01) that arrived without hit set and whose key matched no unit.
- R2: A unit is eligible when its slot reads empty and its address matches no valid entry of its history. Among the eligible units, the lowest index wins. Two back-to-back inserts to the same empty slot address in every unit are therefore granted to unit 0 and then to unit 1.
- R3: An address granted to unit i blocks unit i for the next MEM_LAT-1 cycles, whether or not requests arrive in those cycles. After that window the address no longer blocks unit i.
- R4: Only granted addresses enter a unit's history. An address that a unit reported in a cycle where it lost the election, or where no insert was issued, never blocks that unit later.
- R5: Every result appears at the clock edge that samples the request. `out_valid` follows `in_valid` with one cycle of delay, and key and op code are forwarded unchanged.
- R6: `wb_en` is set exactly when `grant` is non-zero. `wb_addr` then carries the slot address that the granted unit reported.
- R7: An insert with no eligible unit leaves with `out_hit` clear, its own value, no grant and no write-back.
- R8: An insert whose key matches in some unit leaves with `out_hit` set and the stored value of that unit, and no unit is granted.
- R9: For query (2'b00), delete (2'b10) and modify (2'b11), a matching unit turns the request into a hit carrying that unit's value. With no match, the request leaves with hit clear and its own value.
- R10: A request arriving with `in_hit` set leaves with hit set, its own value and no grant, and it records nothing in any history.
- R11: After reset, `out_valid`, `grant` and `wb_en` are clear and every history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming bus item is present |
| in_hit | input | 1 | Item was already answered by an earlier column |
| in_op | input | 2 | 00 query, 01 insert, 10 delete, 11 modify |
| in_key | input | KEY_W | Request key |
| in_val | input | VAL_W | Request value |
| unit_empty | input | N_UNITS | Per unit: read slot is empty |
| unit_match | input | N_UNITS | Per unit: stored key equals request key |
| unit_addr | input | N_UNITS*ADDR_W | Per unit slot address, unit i at bits i*ADDR_W |
| unit_val | input | N_UNITS*VAL_W | Per unit stored value, unit i at bits i*VAL_W |
| out_valid | output | 1 | Outgoing item is present |
| out_hit | output | 1 | Outgoing item has been answered |
| out_op | output | 2 | Forwarded op code |
| out_key | output | KEY_W | Forwarded key |
| out_val | output | VAL_W | Forwarded or answered value |
| grant | output | N_UNITS | One-hot elected unit for an insert |
| wb_en | output | 1 | Write-back strobe for the elected unit |
| wb_addr | output | ADDR_W | Slot address to write |

## Verification
The bound checker watches several properties on every cycle. It checks that the grant is one-hot or zero, that every grant traces back to a fresh insert one cycle earlier, and that write-back agrees with the grant. It checks that pass-through and miss items never write. It also checks that one unit is never granted the same address on two consecutive cycles. The full eligibility rule needs the per-unit history, so only the bench's scenarios can show it: lowest-index election, the exact edge of the MEM_LAT-1 blocking window, the rule that losing units record nothing, and the values chosen for matched requests. These scenarios use directed back-to-back inserts, and random traffic with deliberately narrow address ranges that provokes collisions.

// File: rtl/kv_elect_pkg.sv
package kv_elect_pkg;

  typedef enum logic [1:0] {
    OP_QUERY  = 2'b00,
    OP_INSERT = 2'b01,
    OP_DELETE = 2'b10,
    OP_MODIFY = 2'b11
  } kv_op_e;

  // A request still needs service by this column.
  function automatic logic needs_service(input logic valid, input logic hit);
    return valid && !hit;
  endfunction

  // A request is an insert that this column must try to place.
  function automatic logic wants_slot(input logic valid, input logic hit, input logic [1:0] op);
    return needs_service(valid, hit) && (op == OP_INSERT);
  endfunction

endpackage

// File: rtl/kv_slot_history.sv
// Per-unit shift register of recently granted insert addresses.
module kv_slot_history #(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              clash
);
  logic              hv [DEPTH];
  logic [ADDR_W-1:0] ha [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < DEPTH; d++) begin
        hv[d] <= 1'b0;
        ha[d] <= '0;
      end
    end else begin
      hv[0] <= push_en;
      ha[0] <= push_addr;
      for (int d = 1; d < DEPTH; d++) begin
        hv[d] <= hv[d-1];
        ha[d] <= ha[d-1];
      end
    end
  end

  always_comb begin
    clash = 1'b0;
    for (int d = 0; d < DEPTH; d++) begin
      if (hv[d] && (ha[d] == probe_addr)) clash = 1'b1;
    end
  end
endmodule

// File: rtl/kv_prio_pick.sv
// Fixed priority: lowest set index wins.
module kv_prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic taken;

  always_comb begin
    gnt   = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/kv_lane_select.sv
// AND-OR selection of one lane from a packed bus by a one-hot select.
module kv_lane_select #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic [N-1:0]   sel,
  input  logic [N*W-1:0] bus,
  output logic [W-1:0]   dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) dout = dout | bus[i*W +: W];
    end
  end
endmodule

// File: rtl/kv_insert_elector.sv
module kv_insert_elector
  import kv_elect_pkg::*;
#(
  parameter int N_UNITS = 8,
  parameter int KEY_W   = 32,
  parameter int VAL_W   = 32,
  parameter int ADDR_W  = 10,
  parameter int MEM_LAT = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      in_hit,
  input  logic [1:0]                in_op,
  input  logic [KEY_W-1:0]          in_key,
  input  logic [VAL_W-1:0]          in_val,
  input  logic [N_UNITS-1:0]        unit_empty,
  input  logic [N_UNITS-1:0]        unit_match,
  input  logic [N_UNITS*ADDR_W-1:0] unit_addr,
  input  logic [N_UNITS*VAL_W-1:0]  unit_val,
  output logic                      out_valid,
  output logic                      out_hit,
  output logic [1:0]                out_op,
  output logic [KEY_W-1:0]          out_key,
  output logic [VAL_W-1:0]          out_val,
  output logic [N_UNITS-1:0]        grant,
  output logic                      wb_en,
  output logic [ADDR_W-1:0]         wb_addr
);
  localparam int HIST_D = (MEM_LAT > 1) ? MEM_LAT - 1 : 1;

  // Named internal events
  logic               svc_req;
  logic               ins_req;
  logic               any_match;
  logic               ins_dup;
  logic [N_UNITS-1:0] clash;
  logic [N_UNITS-1:0] eligible;
  logic [N_UNITS-1:0] elect_gnt;
  logic [N_UNITS-1:0] match_gnt;
  logic [VAL_W-1:0]   match_val;
  logic [ADDR_W-1:0]  elect_addr;

  assign svc_req   = needs_service(in_valid, in_hit);
  assign ins_req   = wants_slot(in_valid, in_hit, in_op);
  assign any_match = |unit_match;
  assign ins_dup   = ins_req && any_match;
  assign eligible  = (ins_req && !ins_dup) ? (unit_empty & ~clash) : '0;

  genvar u;
  generate
    for (u = 0; u < N_UNITS; u++) begin : g_unit
      kv_slot_history #(.ADDR_W(ADDR_W), .DEPTH(HIST_D)) i_hist (
        .clk        (clk),
        .rst        (rst),
        .push_en    (elect_gnt[u]),
        .push_addr  (unit_addr[u*ADDR_W +: ADDR_W]),
        .probe_addr (unit_addr[u*ADDR_W +: ADDR_W]),
        .clash      (clash[u])
      );
    end
  endgenerate

  kv_prio_pick #(.N(N_UNITS)) i_elect (.req(eligible),   .gnt(elect_gnt));
  kv_prio_pick #(.N(N_UNITS)) i_match (.req(unit_match), .gnt(match_gnt));

  kv_lane_select #(.N(N_UNITS), .W(VAL_W)) i_val_sel (
    .sel(match_gnt), .bus(unit_val), .dout(match_val)
  );
  kv_lane_select #(.N(N_UNITS), .W(ADDR_W)) i_addr_sel (
    .sel(elect_gnt), .bus(unit_addr), .dout(elect_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_op    <= '0;
      out_key   <= '0;
      out_val   <= '0;
      grant     <= '0;
      wb_en     <= 1'b0;
      wb_addr   <= '0;
    end else begin
      out_valid <= in_valid;
      out_op    <= in_op;
      out_key   <= in_key;
      out_hit   <= in_hit || (svc_req && any_match) || (|elect_gnt);
      out_val   <= (svc_req && any_match) ? match_val : in_val;
      grant     <= elect_gnt;
      wb_en     <= |elect_gnt;
      wb_addr   <= elect_addr;
    end
  end
endmodule

// File: rtl/kv_insert_elector_chk.sv
module kv_insert_elector_chk #(
  parameter int N_UNITS = 8,
  parameter int ADDR_W  = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_hit,
  input logic [1:0]         in_op,
  input logic [N_UNITS-1:0] unit_match,
  input logic               out_valid,
  input logic               out_hit,
  input logic [N_UNITS-1:0] grant,
  input logic               wb_en,
  input logic [ADDR_W-1:0]  wb_addr
);
  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_grant_source_R1: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> $past(in_valid && !in_hit && in_op == 2'b01 && unit_match == '0));

  assert_wb_follows_grant_R6: assert property (@(posedge clk) disable iff (rst)
    wb_en == (grant != '0));

  assert_no_repeat_slot_R3: assert property (@(posedge clk) disable iff (rst)
    ((grant & $past(grant)) != '0) |-> (wb_addr != $past(wb_addr)));

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  assert_passthru_R10: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_hit) |-> (out_hit && grant == '0));

  assert_miss_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_hit) |-> !wb_en);
endmodule

bind kv_insert_elector kv_insert_elector_chk #(
  .N_UNITS(N_UNITS),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_hit    (in_hit),
  .in_op     (in_op),
  .unit_match(unit_match),
  .out_valid (out_valid),
  .out_hit   (out_hit),
  .grant     (grant),
  .wb_en     (wb_en),
  .wb_addr   (wb_addr)
);

// File: tb/test_kv_insert_elector.sv
`timescale 1ns/1ps
module test_kv_insert_elector;
  localparam int N  = 4;
  localparam int KW = 8;
  localparam int VW = 8;
  localparam int AW = 4;
  localparam int ML = 3;
  localparam int D  = ML - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, in_hit = 1'b0;
  logic [1:0]    in_op = 2'b00;
  logic [KW-1:0] in_key = '0;
  logic [VW-1:0] in_val = '0;
  logic [N-1:0]  unit_empty = '0, unit_match = '0;
  logic [N*AW-1:0] unit_addr = '0;
  logic [N*VW-1:0] unit_val = '0;
  logic          out_valid, out_hit;
  logic [1:0]    out_op;
  logic [KW-1:0] out_key;
  logic [VW-1:0] out_val;
  logic [N-1:0]  grant;
  logic          wb_en;
  logic [AW-1:0] wb_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic          mv [N][D];
  logic [AW-1:0] ma [N][D];

  always #2.5 clk = ~clk;

  kv_insert_elector #(.N_UNITS(N), .KEY_W(KW), .VAL_W(VW), .ADDR_W(AW), .MEM_LAT(ML))
  i_kv_insert_elector (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hit(in_hit), .in_op(in_op),
    .in_key(in_key), .in_val(in_val), .unit_empty(unit_empty), .unit_match(unit_match),
    .unit_addr(unit_addr), .unit_val(unit_val), .out_valid(out_valid), .out_hit(out_hit),
    .out_op(out_op), .out_key(out_key), .out_val(out_val), .grant(grant),
    .wb_en(wb_en), .wb_addr(wb_addr)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // Drive one request, apply the edge, then compare with the bench model.
  task automatic cyc(input string tag, input logic v, input logic h, input logic [1:0] op,
                     input logic [KW-1:0] key, input logic [VW-1:0] val,
                     input logic [N-1:0] emp, input logic [N-1:0] mat,
                     input logic [N*AW-1:0] ab, input logic [N*VW-1:0] vb);
    logic [N-1:0]  e_gnt;
    logic          e_hit;
    logic [VW-1:0] e_val;
    logic [AW-1:0] e_addr;
    logic          blk;
    in_valid = v; in_hit = h; in_op = op; in_key = key; in_val = val;
    unit_empty = emp; unit_match = mat; unit_addr = ab; unit_val = vb;
    e_gnt = '0; e_hit = 1'b0; e_val = val; e_addr = '0;
    if (v) begin
      if (h) e_hit = 1'b1;
      else if (mat != '0) begin
        e_hit = 1'b1;
        for (int i = N - 1; i >= 0; i--) if (mat[i]) e_val = vb[i*VW +: VW];
      end else if (op == 2'b01) begin
        for (int i = 0; i < N; i++) begin
          if (e_gnt == '0 && emp[i]) begin
            blk = 1'b0;
            for (int d = 0; d < D; d++)
              if (mv[i][d] && ma[i][d] == ab[i*AW +: AW]) blk = 1'b1;
            if (!blk) begin
              e_gnt[i] = 1'b1;
              e_addr = ab[i*AW +: AW];
              e_hit = 1'b1;
            end
          end
        end
      end
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      for (int d = D - 1; d > 0; d--) begin
        mv[i][d] = mv[i][d-1];
        ma[i][d] = ma[i][d-1];
      end
      mv[i][0] = e_gnt[i];
      ma[i][0] = ab[i*AW +: AW];
    end
    chk(tag, "out_valid", 64'(out_valid), 64'(v));
    if (v) begin
      chk(tag, "hit/val/key/op", 64'({out_hit, out_val, out_key, out_op}), 64'({e_hit, e_val, key, op}));
      chk(tag, "grant/wb", 64'({grant, wb_en, (wb_en ? wb_addr : 4'h0)}),
          64'({e_gnt, (e_gnt != '0), e_addr}));
    end else begin
      chk(tag, "idle grant/wb", 64'({grant, wb_en}), 64'(0));
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc("R3 idle", 1'b0, 1'b0, 2'b00, '0, '0, '0, '0, '0, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++)
      for (int d = 0; d < D; d++) begin mv[i][d] = 1'b0; ma[i][d] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #0;
    chk("R11", "reset outputs", 64'({out_valid, grant, wb_en}), 64'(0));

    // R2: back-to-back inserts to the same empty slot land in different units
    cyc("R2", 1, 0, 2'b01, 8'h11, 8'hA1, 4'hF, 4'h0, 16'h5555, '0);
    chk("R2", "first grant", 64'(grant), 64'(4'b0001));
    cyc("R2", 1, 0, 2'b01, 8'h12, 8'hA2, 4'hF, 4'h0, 16'h5555, '0);
    chk("R2", "b2b distinct", 64'(grant), 64'(4'b0010));
    idle(3);

    // R3: blocking window of MEM_LAT-1 cycles
    cyc("R3", 1, 0, 2'b01, 8'h21, 8'hB1, 4'hF, 4'h0, 16'h5555, '0);
    idle(1);
    cyc("R3", 1, 0, 2'b01, 8'h22, 8'hB2, 4'hF, 4'h0, 16'h5555, '0);
    chk("R3", "inside window", 64'(grant), 64'(4'b0010));
    idle(2);
    cyc("R3", 1, 0, 2'b01, 8'h23, 8'hB3, 4'hF, 4'h0, 16'h5555, '0);
    chk("R3", "after window", 64'(grant), 64'(4'b0001));
    idle(3);

    // R4: a losing unit records nothing
    cyc("R4", 1, 0, 2'b01, 8'h31, 8'hC1, 4'hF, 4'h0, 16'h5555, '0);
    cyc("R4", 1, 0, 2'b01, 8'h32, 8'hC2, 4'hE, 4'h0, 16'h5555, '0);
    chk("R4", "loser reusable", 64'(grant), 64'(4'b0010));
    idle(3);

    // R7: nothing eligible
    cyc("R7", 1, 0, 2'b01, 8'h41, 8'hD1, 4'h0, 4'h0, 16'h5555, '0);
    chk("R7", "miss", 64'({out_hit, out_val, wb_en}), 64'({1'b0, 8'hD1, 1'b0}));

    // R6: write-back address from the granted unit; R5 one-cycle result
    cyc("R6", 1, 0, 2'b01, 8'h51, 8'hE1, 4'hC, 4'h0, 16'h39A2, '0);
    chk("R6", "wb addr", 64'({wb_en, wb_addr, grant}), 64'({1'b1, 4'h9, 4'b0100}));
    chk("R5", "key same edge", 64'(out_key), 64'(8'h51));

    // R8: insert of a key already stored
    cyc("R8", 1, 0, 2'b01, 8'h61, 8'hF1, 4'hF, 4'b0100, 16'h1234, 32'h0077_0000);
    chk("R8", "dup insert", 64'({out_hit, out_val, grant}), 64'({1'b1, 8'h77, 4'b0000}));

    // R9: query hit and delete miss
    cyc("R9", 1, 0, 2'b00, 8'h71, 8'h00, 4'h0, 4'b1000, 16'h0, 32'h5A00_0000);
    chk("R9", "query hit", 64'({out_hit, out_val}), 64'({1'b1, 8'h5A}));
    cyc("R9", 1, 0, 2'b10, 8'h72, 8'h33, 4'hF, 4'b0000, 16'h0, 32'h1111_1111);
    chk("R9", "delete miss", 64'({out_hit, out_val}), 64'({1'b0, 8'h33}));
    cyc("R9", 1, 0, 2'b11, 8'h73, 8'h01, 4'h0, 4'b0010, 16'h0, 32'h0000_4400);

    // R10: already answered item passes through, history untouched
    idle(3);
    cyc("R10", 1, 1, 2'b01, 8'h81, 8'h99, 4'hF, 4'h0, 16'h7777, '0);
    chk("R10", "pass", 64'({out_hit, out_val, grant}), 64'({1'b1, 8'h99, 4'b0000}));
    cyc("R10", 1, 0, 2'b01, 8'h82, 8'h98, 4'hF, 4'h0, 16'h7777, '0);
    chk("R10", "no history", 64'(grant), 64'(4'b0001));

    // R1: random traffic with narrow address range
    for (int k = 0; k < 500; k++) begin
      logic [N*AW-1:0] ab;
      logic [N-1:0] mat;
      for (int i = 0; i < N; i++) ab[i*AW +: AW] = 4'($urandom % 3);
      mat = ($urandom % 4 == 0) ? 4'(1 << ($urandom % N)) : 4'h0;
      cyc("R1", ($urandom % 5) != 0, ($urandom % 6) == 0, 2'($urandom), 8'($urandom), 8'($urandom),
          4'($urandom), mat, ab, 32'($urandom));
    end
    idle(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule